// File: doc/BRIEF.md
# Multi-Channel DMA Configuration Register Bank

This block holds the per-channel setup registers of a DMA engine that has up to eight write channels and eight read channels. Every channel owns eight 32-bit registers: a control word, a transfer length, a 64-bit source address, a 64-bit destination address and a 64-bit pointer to the first linked-list descriptor. Each register value is driven continuously on a flat configuration output, one vector for the write direction and one for the read direction, so the data movers can pick up their setup without a bus access.

A build-time parameter picks one of two ways of reaching the registers from the word-addressed register bus. In the windowed layout, a selector register names a direction and a channel, and a small eight-word window reaches that one channel. In the flat layout, every channel sits at its own fixed-stride slot and needs no selector. Reads return their data one cycle after the request. Writes take effect at the clock edge on which they are presented.

Top module: `dmaregs_bank`

## Requirements
- R1: After reset every channel register, the selector and the read-return outputs are zero.
- R2: A read request is answered on the next cycle with `busRdValid` high for exactly that one cycle and the data on `busRdData`. When `busRdValid` is low, `busRdData` is zero.
- R3: In the windowed layout, word address 0x00 is the selector. Bit 31 picks the direction (0 = write channels, 1 = read channels) and bits 2:0 pick the channel. It reads back those bits as last written, with every other bit reading zero.
- R4: In the windowed layout, word addresses 0x08 to 0x0F reach register `addr[2:0]` of the channel named by the selector. Once the selector changes, all later window accesses go to the newly selected channel.
- R5: The register index order is 0 control, 1 length, 2 source low, 3 source high, 4 destination low, 5 destination high, 6 descriptor pointer low, 7 descriptor pointer high. Register r of channel c appears on `wrCfg`/`rdCfg` bits `[(c*8+r)*32 +: 32]`.
- R6: In the flat layout, register r of channel c is at word address 0x80 + d*0x40 + c*8 + r, where d is 0 for write channels and 1 for read channels. Every channel is reachable without a selector.
- R7: In the flat layout, the selector and window addresses read zero and ignore writes. In the windowed layout, addresses 0x80 to 0xFF read zero and ignore writes.
- R8: A write channel and a read channel with the same index and register are separate storage.
- R9: The source and destination address registers keep all 32 written bits, so any byte alignment is accepted. The descriptor-pointer low register forces bits 1:0 to zero, which gives word alignment.
- R10: A channel index at or above the implemented count for its direction (`NUM_WR` or `NUM_RD`) reads zero. Writes to it are ignored and do not alter any implemented channel.
- R11: Any other word address (0x01 to 0x07 and 0x10 to 0x7F) reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Register access request, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Word address |
| busWdata | input | 32 | Write data |
| busRdValid | output | 1 | Read data valid, one cycle after a read request |
| busRdData | output | 32 | Read data, zero when not valid |
| wrCfg | output | NUM_WR*256 | All write-channel registers, flattened |
| rdCfg | output | NUM_RD*256 | All read-channel registers, flattened |

## Verification
The bench moves the selector between directions and channels in the middle of a sequence and then re-reads earlier values. A decoder that latched the channel too early or too late, or that shared storage between the two directions, would return another channel's data. It writes through a selector that names an unimplemented channel, and through a flat slot past the write-channel count. It then compares the full configuration vectors, so a write that wrapped onto a real channel shows up as a changed word. It also checks that each layout ignores the other layout's addresses, and that odd byte addresses survive in the source register while the descriptor pointer drops its low two bits.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;

  localparam int WORD_W      = 32;
  localparam int ADDR_W      = 8;
  localparam int REGS_PER_CH = 8;
  localparam int MAX_CH      = 8;
  localparam int CH_W        = $clog2(MAX_CH);
  localparam int CH_BITS     = REGS_PER_CH * WORD_W;
  localparam int PTR_ALIGN   = 2;
  localparam logic [WORD_W-1:0] PTR_MASK = ~WORD_W'((1 << PTR_ALIGN) - 1);

  typedef enum logic [2:0] {
    RI_CTRL    = 3'd0,
    RI_SIZE    = 3'd1,
    RI_SRC_LO  = 3'd2,
    RI_SRC_HI  = 3'd3,
    RI_DST_LO  = 3'd4,
    RI_DST_HI  = 3'd5,
    RI_LLP_LO  = 3'd6,
    RI_LLP_HI  = 3'd7
  } regIdx_e;

  typedef struct packed {
    logic              doWrite;
    logic              doRead;
    logic              selValid;
    logic              selDir;
    logic [CH_W-1:0]   selCh;
    regIdx_e           selReg;
    logic              vpSel;
    logic [WORD_W-1:0] vpWord;
  } bankStrb_t;

endpackage

// File: rtl/dmaregs_chan.sv
module dmaregs_chan
  import dmaregs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  regIdx_e              regSel,
  input  logic [WORD_W-1:0]    wdata,
  output logic [CH_BITS-1:0]   cfgFlat,
  output logic [WORD_W-1:0]    rdWord
);

  logic [WORD_W-1:0] regQ [REGS_PER_CH];
  logic [WORD_W-1:0] wrValue;

  // Descriptor pointer is word aligned; address registers keep every bit.
  always_comb begin
    wrValue = wdata;
    if (regSel == RI_LLP_LO) wrValue = wdata & PTR_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS_PER_CH; i++) regQ[i] <= '0;
    end else if (wrEn) begin
      regQ[regSel] <= wrValue;
    end
  end

  for (genvar r = 0; r < REGS_PER_CH; r++) begin : g_flat
    assign cfgFlat[r*WORD_W +: WORD_W] = regQ[r];
  end

  assign rdWord = regQ[regSel];

  a_r9_llp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    regQ[RI_LLP_LO][PTR_ALIGN-1:0] == '0);

  a_r9_src_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && regSel == RI_SRC_LO) |=> regQ[RI_SRC_LO] == $past(wdata));

endmodule

// File: rtl/dmaregs_ctrl.sv
module dmaregs_ctrl
  import dmaregs_pkg::*;
#(
  parameter int NUM_WR   = 8,
  parameter int NUM_RD   = 8,
  parameter bit UNROLLED = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busReq,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               vpDirIn,
  input  logic [CH_W-1:0]    vpChIn,
  output bankStrb_t          strb
);

  localparam logic [ADDR_W-1:0] VP_ADDR  = 8'h00;
  localparam logic [4:0]        WIN_BASE = 5'b00001;

  logic            vpHit, winHit, unrHit;
  logic            vpDirQ;
  logic [CH_W-1:0] vpChQ;
  logic            chDir;
  logic [CH_W-1:0] chIdx;
  logic            chImpl;

  // Region decode: the layout parameter enables exactly one family.
  always_comb begin
    if (UNROLLED) begin
      vpHit  = 1'b0;
      winHit = 1'b0;
      unrHit = busAddr[7];
      chDir  = busAddr[6];
      chIdx  = busAddr[5:3];
    end else begin
      vpHit  = (busAddr == VP_ADDR);
      winHit = (busAddr[7:3] == WIN_BASE);
      unrHit = 1'b0;
      chDir  = vpDirQ;
      chIdx  = vpChQ;
    end
    chImpl = chDir ? (int'(chIdx) < NUM_RD) : (int'(chIdx) < NUM_WR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpDirQ <= 1'b0;
      vpChQ  <= '0;
    end else if (busReq && busWe && vpHit) begin
      vpDirQ <= vpDirIn;
      vpChQ  <= vpChIn;
    end
  end

  always_comb begin
    strb          = '0;
    strb.doWrite  = busReq && busWe;
    strb.doRead   = busReq && !busWe;
    strb.selValid = (winHit || unrHit) && chImpl;
    strb.selDir   = chDir;
    strb.selCh    = chIdx;
    strb.selReg   = regIdx_e'(busAddr[2:0]);
    strb.vpSel    = vpHit;
    strb.vpWord   = {vpDirQ, {(WORD_W-1-CH_W){1'b0}}, vpChQ};
  end

  a_r7_one_region: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vpHit, winHit, unrHit}));

  a_r3_vp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(busReq && busWe && vpHit) |=> $stable(strb.vpWord));

endmodule

// File: rtl/dmaregs_store.sv
module dmaregs_store
  import dmaregs_pkg::*;
#(
  parameter int NUM_WR = 8,
  parameter int NUM_RD = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  bankStrb_t                  strb,
  input  logic [WORD_W-1:0]          busWdata,
  output logic                       busRdValid,
  output logic [WORD_W-1:0]          busRdData,
  output logic [NUM_WR*CH_BITS-1:0]  wrCfg,
  output logic [NUM_RD*CH_BITS-1:0]  rdCfg
);

  logic [WORD_W-1:0] wrWord [MAX_CH];
  logic [WORD_W-1:0] rdWord [MAX_CH];
  logic              chWrite;

  assign chWrite = strb.doWrite && strb.selValid;

  for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
    if (c < NUM_WR) begin : g_wr
      dmaregs_chan u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrEn    (chWrite && !strb.selDir && strb.selCh == CH_W'(c)),
        .regSel  (strb.selReg),
        .wdata   (busWdata),
        .cfgFlat (wrCfg[c*CH_BITS +: CH_BITS]),
        .rdWord  (wrWord[c])
      );
    end else begin : g_wr_none
      assign wrWord[c] = '0;
    end
    if (c < NUM_RD) begin : g_rd
      dmaregs_chan u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrEn    (chWrite && strb.selDir && strb.selCh == CH_W'(c)),
        .regSel  (strb.selReg),
        .wdata   (busWdata),
        .cfgFlat (rdCfg[c*CH_BITS +: CH_BITS]),
        .rdWord  (rdWord[c])
      );
    end else begin : g_rd_none
      assign rdWord[c] = '0;
    end
  end

  logic [WORD_W-1:0] rdNext;

  always_comb begin
    rdNext = '0;
    if (strb.vpSel)         rdNext = strb.vpWord;
    else if (strb.selValid) rdNext = strb.selDir ? rdWord[strb.selCh] : wrWord[strb.selCh];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busRdValid <= 1'b0;
      busRdData  <= '0;
    end else begin
      busRdValid <= strb.doRead;
      busRdData  <= strb.doRead ? rdNext : '0;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    strb.doRead |=> busRdValid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.doRead |=> !busRdValid);

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busRdValid |-> busRdData == '0);

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.doRead && !strb.selValid && !strb.vpSel) |=> busRdData == '0);

endmodule

// File: rtl/dmaregs_bank.sv
module dmaregs_bank
  import dmaregs_pkg::*;
#(
  parameter int NUM_WR   = 8,
  parameter int NUM_RD   = 8,
  parameter bit UNROLLED = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       busReq,
  input  logic                       busWe,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [WORD_W-1:0]          busWdata,
  output logic                       busRdValid,
  output logic [WORD_W-1:0]          busRdData,
  output logic [NUM_WR*CH_BITS-1:0]  wrCfg,
  output logic [NUM_RD*CH_BITS-1:0]  rdCfg
);

  bankStrb_t strb;

  dmaregs_ctrl #(
    .NUM_WR   (NUM_WR),
    .NUM_RD   (NUM_RD),
    .UNROLLED (UNROLLED)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .busReq  (busReq),
    .busWe   (busWe),
    .busAddr (busAddr),
    .vpDirIn (busWdata[WORD_W-1]),
    .vpChIn  (busWdata[CH_W-1:0]),
    .strb    (strb)
  );

  dmaregs_store #(
    .NUM_WR (NUM_WR),
    .NUM_RD (NUM_RD)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .busWdata   (busWdata),
    .busRdValid (busRdValid),
    .busRdData  (busRdData),
    .wrCfg      (wrCfg),
    .rdCfg      (rdCfg)
  );

endmodule

// File: tb/dmaregs_bank_tb.sv
module dmaregs_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LW = 6, LR = 3;   // windowed instance
  localparam int UW = 5, UR = 8;   // flat instance

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqL = 1'b0, reqU = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rvL, rvU;
  logic [31:0] rdL, rdU;
  logic [LW*256-1:0] wrCfgL;
  logic [LR*256-1:0] rdCfgL;
  logic [UW*256-1:0] wrCfgU;
  logic [UR*256-1:0] rdCfgU;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaregs_bank #(.NUM_WR(LW), .NUM_RD(LR), .UNROLLED(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .busReq(reqL), .busWe(we), .busAddr(addr),
    .busWdata(wdata), .busRdValid(rvL), .busRdData(rdL),
    .wrCfg(wrCfgL), .rdCfg(rdCfgL));

  dmaregs_bank #(.NUM_WR(UW), .NUM_RD(UR), .UNROLLED(1'b1)) u_dut_flat (
    .clk(clk), .rst_n(rst_n), .busReq(reqU), .busWe(we), .busAddr(addr),
    .busWdata(wdata), .busRdValid(rvU), .busRdData(rdU),
    .wrCfg(wrCfgU), .rdCfg(rdCfgU));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkWide(input string tag, input logic [2047:0] act, input logic [2047:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input bit flat, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    if (flat) reqU = 1'b1; else reqL = 1'b1;
    @(negedge clk);
    reqU = 1'b0; reqL = 1'b0; we = 1'b0;
  endtask

  // Read: request held over one edge, data sampled at the following negedge.
  task automatic busRead(input bit flat, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    we = 1'b0; addr = a;
    if (flat) reqU = 1'b1; else reqL = 1'b1;
    @(negedge clk);
    reqU = 1'b0; reqL = 1'b0;
    d = flat ? rdU : rdL;
    check("R2 read valid one cycle after request", {31'd0, flat ? rvU : rvL}, 32'd1);
  endtask

  // {we, addr, wdata, expected read data}
  localparam int NV = 24;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h0000_0002, 32'h0},          // R3 select write ch2
    {1'b1, 8'h0A, 32'h1234_5677, 32'h0},          // R9 odd byte source
    {1'b1, 8'h0E, 32'hABCD_EF03, 32'h0},          // R9 pointer low
    {1'b0, 8'h0A, 32'h0,         32'h1234_5677},  // R4 R9
    {1'b0, 8'h0E, 32'h0,         32'hABCD_EF00},  // R9 low bits cleared
    {1'b1, 8'h00, 32'h8000_0002, 32'h0},          // R3 select read ch2
    {1'b0, 8'h0A, 32'h0,         32'h0},          // R8 separate storage
    {1'b1, 8'h0A, 32'h5555_AAAA, 32'h0},
    {1'b0, 8'h0A, 32'h0,         32'h5555_AAAA},  // R4
    {1'b0, 8'h00, 32'h0,         32'h8000_0002},  // R3 readback
    {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},          // R3 only dir and ch kept
    {1'b0, 8'h00, 32'h0,         32'h8000_0007},  // R3
    {1'b1, 8'h0B, 32'hDEAD_BEEF, 32'h0},          // R10 read ch7 absent
    {1'b0, 8'h0B, 32'h0,         32'h0},          // R10
    {1'b1, 8'h00, 32'h0000_0002, 32'h0},          // R4 back to write ch2
    {1'b0, 8'h0A, 32'h0,         32'h1234_5677},  // R4 R8
    {1'b1, 8'h03, 32'h1111_1111, 32'h0},          // R11
    {1'b0, 8'h03, 32'h0,         32'h0},          // R11
    {1'b1, 8'h82, 32'h0000_2222, 32'h0},          // R7 flat slot in windowed mode
    {1'b0, 8'h82, 32'h0,         32'h0},          // R7
    {1'b1, 8'h40, 32'h3333_3333, 32'h0},          // R11
    {1'b0, 8'h40, 32'h0,         32'h0},          // R11
    {1'b1, 8'h08, 32'h0000_C0DE, 32'h0},          // R5 control of write ch2
    {1'b0, 8'h08, 32'h0,         32'h0000_C0DE}   // R5
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [2047:0] expW;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 windowed valid after reset", {31'd0, rvL}, 32'd0);
    check("R1 flat data after reset", rdU, 32'd0);
    checkWide("R1 windowed write cfg zero", 2048'(wrCfgL), '0);
    checkWide("R1 flat read cfg zero", 2048'(rdCfgU), '0);
    busRead(1'b0, 8'h00, d);
    check("R1 selector reads zero", d, 32'd0);

    // Windowed layout vector walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) busWrite(1'b0, VEC[i][71:64], VEC[i][63:32]);
      else begin
        busRead(1'b0, VEC[i][71:64], d);
        check($sformatf("R4 windowed vector %0d", i), d, VEC[i][31:0]);
      end
    end

    // R2 idle after a read
    @(negedge clk);
    check("R2 valid low when idle", {31'd0, rvL}, 32'd0);
    check("R2 data zero when idle", rdL, 32'd0);

    // R5 output layout, R8 separation, R9 masking on windowed instance
    check("R5 write ch2 source low on wrCfg", wrCfgL[(2*8+2)*32 +: 32], 32'h1234_5677);
    check("R5 write ch2 control on wrCfg", wrCfgL[(2*8+0)*32 +: 32], 32'h0000_C0DE);
    check("R9 write ch2 pointer low on wrCfg", wrCfgL[(2*8+6)*32 +: 32], 32'hABCD_EF00);
    check("R8 read ch2 source low on rdCfg", rdCfgL[(2*8+2)*32 +: 32], 32'h5555_AAAA);
    expW = '0;
    expW[(2*8+2)*32 +: 32] = 32'h5555_AAAA;
    checkWide("R10 read cfg untouched by absent channel", 2048'(rdCfgL), expW);

    // R6 flat layout
    busWrite(1'b1, 8'h80, 32'h0000_00A0);          // write ch0 control
    busWrite(1'b1, 8'h80 + 32 + 7, 32'h0000_00B7); // write ch4 pointer high
    busWrite(1'b1, 8'hC0 + 56 + 4, 32'h0000_00C4); // read ch7 destination low
    busRead(1'b1, 8'h80, d);
    check("R6 flat write ch0 control", d, 32'h0000_00A0);
    busRead(1'b1, 8'h80 + 32 + 7, d);
    check("R6 flat write ch4 pointer high", d, 32'h0000_00B7);
    busRead(1'b1, 8'hC0 + 56 + 4, d);
    check("R6 flat read ch7 destination low", d, 32'h0000_00C4);
    busRead(1'b1, 8'hC0, d);
    check("R8 flat read ch0 control separate", d, 32'h0);
    check("R5 flat rdCfg layout", rdCfgU[(7*8+4)*32 +: 32], 32'h0000_00C4);

    // R10 absent write channel in flat mode, R7 window addresses inert
    busWrite(1'b1, 8'h80 + 40, 32'h0000_00EE);
    busRead(1'b1, 8'h80 + 40, d);
    check("R10 flat absent write ch5 reads zero", d, 32'h0);
    busWrite(1'b1, 8'h00, 32'h8000_0001);
    busRead(1'b1, 8'h00, d);
    check("R7 selector inert in flat mode", d, 32'h0);
    busWrite(1'b1, 8'h08, 32'h0000_FFFF);
    busRead(1'b1, 8'h08, d);
    check("R7 window inert in flat mode", d, 32'h0);
    expW = '0;
    expW[(0*8+0)*32 +: 32] = 32'h0000_00A0;
    expW[(4*8+7)*32 +: 32] = 32'h0000_00B7;
    checkWide("R10 R7 flat write cfg exact", 2048'(wrCfgU), expW);

    // R9 source high keeps every bit in flat mode
    busWrite(1'b1, 8'hC0 + 8 + 3, 32'hFFFF_FFFF);
    busRead(1'b1, 8'hC0 + 8 + 3, d);
    check("R9 flat source high full width", d, 32'hFFFF_FFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule